// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt and Wake Unit

This block watches a wide set of general-purpose pins, grouped into equal banks, for level transitions. Every pin passes through a two-flop synchronizer. The synchronized value is then compared with the value held for that pin from the previous clock. When a pin is configured as an input and its rising or falling enable matches the transition it made, the pin's status bit is set. That bit stays set until software writes a one to the matching clear strobe.

The status vector drives three registered interrupt lines. Pin 0 and pin 1 each have a line of their own. Every other pin shares a single OR-ed line. The block also raises a one-cycle wake request when the core is halted and an input pin that appears in a fixed per-bank wake-capable mask changes level. Register decode and the halt logic live outside the block. The configuration vectors and clear strobes arrive here already decoded.

Top module: `gpio_edge_irq`

## Requirements
- R1: A low-to-high transition on a pin whose direction bit is 0 (input) and whose rising enable is 1 sets that pin's status bit.
- R2: A high-to-low transition on an input pin whose falling enable is 1 sets that pin's status bit.
- R3: A pin whose direction bit is 1 (output) never sets its status bit, whatever its enables. An input pin whose enable for the transition it made is 0 does not set its status bit either.
- R4: A status bit stays set until a cycle in which its clear strobe is 1. A clear strobe on a bit that is already 0 has no effect.
- R5: When a recorded edge and a clear strobe hit the same bit in the same cycle, the bit stays set.
- R6: irq_pin0 follows status bit 0 and irq_pin1 follows status bit 1, each one clock later.
- R7: irq_rest is the OR of status bits 2 and up, one clock later.
- R8: wake_pulse is high for one cycle when core_halted is 1 and an input pin marked in the wake mask changes level. The wake masks for banks 0 to 3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F, with bit n of a mask standing for bit n of that bank. No pulse is raised when the core is not halted, for output pins, or for pins outside the mask.
- R9: After reset, status, all interrupt lines and wake_pulse are 0. A pin change driven before clock edge E1 shows in status and wake_pulse after edge E3, and in the interrupt lines after edge E4.
- R10: The stored previous level follows every input change, even one that records no edge. Enabling an edge afterwards does not report that earlier transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_async | input | NUM_BANKS*BANK_W | Raw pin levels, asynchronous |
| dir_out | input | NUM_BANKS*BANK_W | Direction per pin, 1 = output |
| rise_en | input | NUM_BANKS*BANK_W | Rising-edge enable per pin |
| fall_en | input | NUM_BANKS*BANK_W | Falling-edge enable per pin |
| clr_req | input | NUM_BANKS*BANK_W | Write-one-to-clear strobes for status |
| core_halted | input | 1 | Core is halted |
| status | output | NUM_BANKS*BANK_W | Sticky edge status bits |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_rest | output | 1 | Aggregate interrupt for pins 2 and up |
| wake_pulse | output | 1 | One-cycle wake request |

## Verification
A pin change takes two synchronizer edges to reach the comparator. Status and wake_pulse therefore update on the third clock edge after the change, and the interrupt lines on the fourth. A clear strobe takes effect on the first edge and reaches the interrupt lines on the second. Each scenario task drives its inputs on a falling edge and then advances a counted number of rising edges. It samples on the falling edge that follows the cycle in which a result is due. It also checks the cycle just before, to confirm the result has not arrived early. The same-cycle collision case places its clear strobe on exactly the third edge after the pin change.

// File: rtl/gpio_edge_pkg.sv
// Shared constants and the fixed wake-capable pin map.
// Assumes banks of at most 32 pins; banks beyond the fourth have no wake pins.
package gpio_edge_pkg;

    localparam int MAX_BANK_W = 32;

    // Wake-capable pin mask for a given bank index
    function automatic logic [MAX_BANK_W-1:0] wake_mask(input int bank);
        case (bank)
            0:       return 32'h8003_FE1B;
            1:       return 32'h0020_01FC;
            2:       return 32'hEC08_0000;
            3:       return 32'h0012_007F;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; there is no multi-bit coherence.
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    // Two-stage capture of the raw inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_sync <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_edge_bank.sv
// Edge detection and sticky status for one bank of pins.
// Assumes lvl is already synchronized. An edge sets status in the cycle after
// the comparator sees it; a set beats a same-cycle clear.
module gpio_edge_bank #(
    parameter int          BANK_W    = 32,
    parameter logic [31:0] WAKE_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lvl,
    input  logic [BANK_W-1:0] dir_out,
    input  logic [BANK_W-1:0] rise_en,
    input  logic [BANK_W-1:0] fall_en,
    input  logic [BANK_W-1:0] clr_req,
    output logic [BANK_W-1:0] status,
    output logic [BANK_W-1:0] set_vec,
    output logic              wake_hit
);
    logic [BANK_W-1:0] prev_q;
    logic [BANK_W-1:0] changed;
    logic [BANK_W-1:0] is_in;

    // Transition classification against the previous level
    always_comb begin
        changed  = lvl ^ prev_q;
        is_in    = ~dir_out;
        set_vec  = is_in & ((rise_en & lvl & ~prev_q) | (fall_en & ~lvl & prev_q));
        wake_hit = |(changed & is_in & WAKE_MASK[BANK_W-1:0]);
    end

    // Previous level tracks every change; status is sticky with set priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            status <= '0;
        end else begin
            prev_q <= lvl;
            status <= (status & ~clr_req) | set_vec;
        end
    end
endmodule

// File: rtl/gpio_irq_combine.sv
// Registered interrupt outputs: two dedicated pins plus an OR of the rest.
// Assumes NPINS >= 3.
module gpio_irq_combine #(
    parameter int NPINS = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] status,
    output logic             irq_pin0,
    output logic             irq_pin1,
    output logic             irq_rest
);
    // One register stage on every interrupt line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pin0 <= 1'b0;
            irq_pin1 <= 1'b0;
            irq_rest <= 1'b0;
        end else begin
            irq_pin0 <= status[0];
            irq_pin1 <= status[1];
            irq_rest <= |status[NPINS-1:2];
        end
    end
endmodule

// File: rtl/gpio_edge_irq.sv
// Top of the edge-detect interrupt and wake unit.
// Assumes configuration vectors and clear strobes come from an external decoder,
// and core_halted is synchronous to clk.
module gpio_edge_irq #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 32,
    localparam int NPINS    = NUM_BANKS * BANK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_async,
    input  logic [NPINS-1:0] dir_out,
    input  logic [NPINS-1:0] rise_en,
    input  logic [NPINS-1:0] fall_en,
    input  logic [NPINS-1:0] clr_req,
    input  logic             core_halted,
    output logic [NPINS-1:0] status,
    output logic             irq_pin0,
    output logic             irq_pin1,
    output logic             irq_rest,
    output logic             wake_pulse
);
    logic [NPINS-1:0]     lvl_sync;
    logic [NPINS-1:0]     set_vec;
    logic [NUM_BANKS-1:0] wake_hit;

    gpio_sync2 #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_async),
        .q_sync  (lvl_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO = b * BANK_W;
        gpio_edge_bank #(
            .BANK_W    (BANK_W),
            .WAKE_MASK (gpio_edge_pkg::wake_mask(b))
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (lvl_sync[LO +: BANK_W]),
            .dir_out  (dir_out[LO +: BANK_W]),
            .rise_en  (rise_en[LO +: BANK_W]),
            .fall_en  (fall_en[LO +: BANK_W]),
            .clr_req  (clr_req[LO +: BANK_W]),
            .status   (status[LO +: BANK_W]),
            .set_vec  (set_vec[LO +: BANK_W]),
            .wake_hit (wake_hit[b])
        );
    end

    gpio_irq_combine #(.NPINS(NPINS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .status   (status),
        .irq_pin0 (irq_pin0),
        .irq_pin1 (irq_pin1),
        .irq_rest (irq_rest)
    );

    // Wake request registered from any bank hit while halted
    always_ff @(posedge clk) begin
        if (!rst_n) wake_pulse <= 1'b0;
        else        wake_pulse <= core_halted & (|wake_hit);
    end
endmodule

// File: rtl/gpio_edge_irq_chk.sv
// Assertion checker for gpio_edge_irq, attached by bind.
module gpio_edge_irq_chk #(
    parameter int NPINS = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] dir_out,
    input logic [NPINS-1:0] clr_req,
    input logic             core_halted,
    input logic [NPINS-1:0] status,
    input logic [NPINS-1:0] set_vec,
    input logic             irq_pin0,
    input logic             irq_pin1,
    input logic             irq_rest,
    input logic             wake_pulse
);
    AST_OUTPUT_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & $past(dir_out)) == '0)); // R3
    AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(status) & ~status & ~$past(clr_req)) == '0)); // R4
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec))); // R5
    AST_IRQ0_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|status[1:0]) |=> (irq_pin0 == $past(status[0]) && irq_pin1 == $past(status[1]))); // R6
    AST_IRQ_REST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|status[NPINS-1:2]) |=> irq_rest); // R7
    AST_WAKE_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(core_halted)); // R8
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NPINS(NPINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dir_out     (dir_out),
    .clr_req     (clr_req),
    .core_halted (core_halted),
    .status      (status),
    .set_vec     (set_vec),
    .irq_pin0    (irq_pin0),
    .irq_pin1    (irq_pin1),
    .irq_rest    (irq_rest),
    .wake_pulse  (wake_pulse)
);

// File: tb/gpio_edge_irq_bench.sv
module gpio_edge_irq_bench;
    localparam int N = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_async = '0, dir_out = '0, rise_en = '0, fall_en = '0, clr_req = '0;
    logic         core_halted = 1'b0;
    logic [N-1:0] status;
    logic         irq_pin0, irq_pin1, irq_rest, wake_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [N-1:0] exp_st = '0;

    always #5 clk = ~clk;

    gpio_edge_irq u_gpio_edge_irq (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .dir_out(dir_out),
        .rise_en(rise_en), .fall_en(fall_en), .clr_req(clr_req),
        .core_halted(core_halted), .status(status), .irq_pin0(irq_pin0),
        .irq_pin1(irq_pin1), .irq_rest(irq_rest), .wake_pulse(wake_pulse)
    );

    task automatic chk(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Advance n rising edges, stop on the next falling edge
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R9", "status after reset", status, '0);
        chk("R9", "irq lines after reset", {irq_pin0, irq_pin1, irq_rest}, '0);
        chk("R9", "wake after reset", wake_pulse, 1'b0);
    endtask

    task automatic t_rise();
        rise_en[5] = 1'b1;
        pin_async[5] = 1'b1;
        tick(2);
        chk("R9", "status not early", status, exp_st);
        tick(1);
        exp_st[5] = 1'b1;
        chk("R1", "rising edge pin 5", status, exp_st);
        chk("R7", "irq_rest not early", irq_rest, 1'b0);
        tick(1);
        chk("R7", "irq_rest after edge", irq_rest, 1'b1);
    endtask

    task automatic t_fall();
        fall_en[40] = 1'b1;
        pin_async[40] = 1'b1;
        tick(4);
        chk("R2", "rise on fall-only pin ignored", status, exp_st);
        pin_async[40] = 1'b0;
        tick(3);
        exp_st[40] = 1'b1;
        chk("R2", "falling edge pin 40", status, exp_st);
        // R10: transition while disabled, then enable: no late report
        pin_async[41] = 1'b1;
        tick(4);
        rise_en[41] = 1'b1;
        tick(4);
        chk("R10", "earlier rise not reported", status, exp_st);
    endtask

    task automatic t_output();
        dir_out[70] = 1'b1; rise_en[70] = 1'b1; fall_en[70] = 1'b1;
        pin_async[70] = 1'b1; tick(3);
        pin_async[70] = 1'b0; tick(3);
        chk("R3", "output pin sets nothing", status, exp_st);
        pin_async[71] = 1'b1; tick(3);
        pin_async[71] = 1'b0; tick(3);
        chk("R3", "disabled input sets nothing", status, exp_st);
        chk("R4", "status sticky", status[5], 1'b1);
    endtask

    task automatic t_clear();
        clr_req[5] = 1'b1; clr_req[40] = 1'b1; clr_req[100] = 1'b1;
        tick(1);
        clr_req = '0;
        exp_st[5] = 1'b0; exp_st[40] = 1'b0;
        chk("R4", "clear strobes", status, exp_st);
        chk("R7", "irq_rest one cycle late", irq_rest, 1'b1);
        tick(1);
        chk("R7", "irq_rest dropped", irq_rest, 1'b0);
        chk("R4", "status stays clear", status, exp_st);
    endtask

    task automatic t_collide();
        rise_en[3] = 1'b1;
        pin_async[3] = 1'b1; tick(3);
        exp_st[3] = 1'b1;
        chk("R1", "rising edge pin 3", status, exp_st);
        pin_async[3] = 1'b0; tick(4);
        pin_async[3] = 1'b1;
        tick(2);
        clr_req[3] = 1'b1;
        tick(1);
        clr_req = '0;
        chk("R5", "edge wins over same-cycle clear", status, exp_st);
        clr_req[3] = 1'b1; tick(1); clr_req = '0;
        exp_st[3] = 1'b0;
        chk("R4", "later clear works", status, exp_st);
        tick(1);
    endtask

    task automatic t_irq01();
        rise_en[0] = 1'b1;
        pin_async[0] = 1'b1; tick(3);
        chk("R6", "status0 set, irq_pin0 not early", {status[0], irq_pin0}, 2'b10);
        tick(1);
        chk("R6", "irq_pin0 only", {irq_pin0, irq_pin1, irq_rest}, 3'b100);
        clr_req[0] = 1'b1; tick(1); clr_req = '0;
        tick(1);
        chk("R6", "irq_pin0 cleared", irq_pin0, 1'b0);
        rise_en[0] = 1'b0;
        pin_async[0] = 1'b0;
        rise_en[1] = 1'b1;
        pin_async[1] = 1'b1; tick(4);
        chk("R6", "irq_pin1 only", {irq_pin0, irq_pin1, irq_rest}, 3'b010);
        clr_req[1] = 1'b1; tick(1); clr_req = '0;
        rise_en[1] = 1'b0;
        pin_async[1] = 1'b0; tick(4);
        chk("R6", "irq_pin1 cleared", irq_pin1, 1'b0);
    endtask

    task automatic t_wake();
        core_halted = 1'b1;
        pin_async[0] = 1'b1; tick(2);
        chk("R8", "wake not early", wake_pulse, 1'b0);
        tick(1);
        chk("R8", "wake pin 0 (bank0 bit0)", wake_pulse, 1'b1);
        tick(1);
        chk("R8", "wake one cycle", wake_pulse, 1'b0);
        pin_async[2] = 1'b1; tick(3);
        chk("R8", "pin 2 not wake-capable", wake_pulse, 1'b0);
        pin_async[95] = 1'b1; tick(3);
        chk("R8", "wake pin 95 (bank2 bit31)", wake_pulse, 1'b1);
        dir_out[1] = 1'b1;
        pin_async[1] = 1'b1; tick(3);
        chk("R8", "output pin no wake", wake_pulse, 1'b0);
        core_halted = 1'b0;
        pin_async[0] = 1'b0; tick(3);
        chk("R8", "not halted no wake", wake_pulse, 1'b0);
        chk("R3", "no status from wake pins", status, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rise();
        t_fall();
        t_output();
        t_clear();
        t_collide();
        t_irq01();
        t_wake();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule